// File: doc/BRIEF.md
# Single-Precision Result Packer

This block takes a floating-point value held in a wide working format and turns it into a 32-bit IEEE-754 single-precision word. The working format has five parts: a class tag, a sign, a signed unbiased exponent, a normalised mantissa with extra low-order bits, and a sticky input. A rounding mode and an underflow-trap-enable input come with the value. The block rounds in one of four modes. It slides values that are too small for the normal range into the subnormal range, and it saturates values that are too large. It also raises overflow, underflow, inexact and rounded-up flags.

The block is a single register stage. The inputs are sampled at each rising clock edge, and the packed word and its flags appear on the outputs after that edge. The block has no valid signal, so a new value can be presented on every cycle.

Top module: `fp32_packer`

## Requirements
- R1: Class 3 (NaN) gives exponent field 255 and bit 22 set. Fraction bits 21:0 are copied from `val_mant` bits 29:8. The sign is kept and all four flags are 0.
- R2: Class 0 (zero) gives only the sign in bit 31. Class 2 (infinity) gives the sign, exponent field 255 and fraction 0. Mantissa, sticky, mode and trap-enable have no effect on either class, and all flags are 0.
- R3: Class 1 (number) treats `val_mant` bit 31 as the implied one. The biased exponent is `val_exp`+127. The output has the sign in bit 31, the exponent in bits 30:23 and the 23 mantissa bits below the implied one in bits 22:0.
- R4: On the normal path the 24 kept bits are mantissa 31:8. Bit 7 is the guard bit and bit 6 is the round bit. The sticky bit is the OR of bits 5:0 and `val_sticky`. Mode 0 rounds to nearest with ties to even, mode 1 rounds toward zero, mode 2 rounds toward +inf and mode 3 rounds toward -inf.
- R5: `flag_inx` is set when any discarded bit is nonzero. `flag_frnd` is set when the magnitude was rounded up.
- R6: When a normal value rounds up into 2.0, the exponent goes up by one and the fraction becomes 0.
- R7: If the biased exponent is 0 or less, the mantissa and its implied one are shifted right by another (1 - biased exponent) places before rounding, and the exponent field is 0. Shifts larger than the mantissa width push every bit into sticky.
- R8: When a subnormal rounds up into bit 23, the result is the smallest normal: exponent 1, fraction 0. No underflow is raised in that case.
- R9: A result that stays subnormal sets `flag_unf` if it is inexact or if `unf_trap_en` is 1.
- R10: A final biased exponent of 255 or more sets `flag_ovf`. The result is then infinity or the largest finite value (exponent 254, fraction all ones) with the same sign. Mode 0 always gives infinity and mode 1 never does. Mode 2 gives infinity only for positive values, and mode 3 only for negative values.
- R11: Outputs change only at a rising clock edge, one cycle after the inputs. While `rst_n` is low, the result and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| val_class | input | 2 | 0 zero, 1 number, 2 infinity, 3 NaN |
| val_sign | input | 1 | Sign of the value |
| val_exp | input | EXP_W | Signed unbiased exponent |
| val_mant | input | MANT_W | Mantissa, MSB is the implied one |
| val_sticky | input | 1 | OR of bits lost before this block |
| rnd_mode | input | 2 | Rounding mode |
| unf_trap_en | input | 1 | Underflow trap enable |
| result | output | 32 | Packed single-precision word |
| flag_ovf | output | 1 | Overflow |
| flag_unf | output | 1 | Underflow |
| flag_inx | output | 1 | Inexact |
| flag_frnd | output | 1 | Fraction rounded up |

## Verification
The only state is the output register, so a wrong shift amount, rounding decision or path selection shows up in the word produced on the very next cycle. A misjudged guard, round or sticky bit moves the fraction LSB by one and also flips `flag_inx` or `flag_frnd`. A wrong subnormal or overflow boundary changes the exponent field and the underflow or overflow flag together. For this reason, the vectors sit on each boundary: exponent -127 against -126, 254 against 255, and shifts of 23, 24 and beyond the mantissa width.

// File: rtl/fp32_packer.sv
module fp32_packer #(
  parameter int EXP_W  = 10,
  parameter int MANT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        val_class,
  input  logic              val_sign,
  input  logic [EXP_W-1:0]  val_exp,
  input  logic [MANT_W-1:0] val_mant,
  input  logic              val_sticky,
  input  logic [1:0]        rnd_mode,
  input  logic              unf_trap_en,
  output logic [31:0]       result,
  output logic              flag_ovf,
  output logic              flag_unf,
  output logic              flag_inx,
  output logic              flag_frnd
);
  localparam int BW = EXP_W + 2;
  localparam int XW = 2 * MANT_W;
  localparam logic [BW-1:0] BIAS = BW'(127);
  localparam logic [BW-1:0] SHMAX = BW'(MANT_W);

  logic [BW-1:0] bexp, sh_raw, sh, bexp_n;
  logic          subn;
  logic [XW-1:0] ext;
  logic [23:0]   kept;
  logic          g, r, s, inexact, up, toinf, ovf;
  logic [24:0]   sum;
  logic [31:0]   res_d;
  logic [3:0]    flg_d;

  assign bexp   = {{2{val_exp[EXP_W-1]}}, val_exp} + BIAS;
  assign subn   = bexp[BW-1] | (bexp == '0);
  assign sh_raw = BW'(1) - bexp;
  assign sh     = !subn ? '0 : (sh_raw > SHMAX ? SHMAX : sh_raw);
  assign ext    = {val_mant, {MANT_W{1'b0}}} >> sh;

  assign kept    = ext[XW-1 -: 24];
  assign g       = ext[XW-25];
  assign r       = ext[XW-26];
  assign s       = (|ext[XW-27:0]) | val_sticky;
  assign inexact = g | r | s;

  always_comb begin
    case (rnd_mode)
      2'd0:    up = g & (r | s | kept[0]);
      2'd1:    up = 1'b0;
      2'd2:    up = inexact & ~val_sign;
      default: up = inexact & val_sign;
    endcase
    case (rnd_mode)
      2'd0:    toinf = 1'b1;
      2'd1:    toinf = 1'b0;
      2'd2:    toinf = ~val_sign;
      default: toinf = val_sign;
    endcase
  end

  assign sum    = {1'b0, kept} + 25'(up);
  assign bexp_n = bexp + BW'(sum[24]);
  assign ovf    = !subn && (bexp_n >= BW'(255));

  always_comb begin
    res_d = {val_sign, 31'd0};
    flg_d = 4'b0000;
    case (val_class)
      2'd0: res_d = {val_sign, 31'd0};
      2'd2: res_d = {val_sign, 8'hFF, 23'd0};
      2'd3: res_d = {val_sign, 8'hFF, 1'b1, val_mant[MANT_W-3 -: 22]};
      default: begin
        flg_d[1] = inexact;
        flg_d[0] = up;
        if (subn) begin
          res_d    = {val_sign, 7'd0, sum[23], sum[22:0]};
          flg_d[2] = !sum[23] && (inexact || unf_trap_en);
        end else if (ovf) begin
          flg_d[3] = 1'b1;
          res_d    = toinf ? {val_sign, 8'hFF, 23'd0} : {val_sign, 8'hFE, 23'h7FFFFF};
        end else begin
          res_d = {val_sign, bexp_n[7:0], sum[22:0]};
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result <= '0;
      {flag_ovf, flag_unf, flag_inx, flag_frnd} <= '0;
    end else begin
      result <= res_d;
      {flag_ovf, flag_unf, flag_inx, flag_frnd} <= flg_d;
    end
  end
endmodule

// File: rtl/fp32_packer_chk.sv
module fp32_packer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  val_class,
  input logic [1:0]  rnd_mode,
  input logic [31:0] result,
  input logic        flag_ovf,
  input logic        flag_unf,
  input logic        flag_inx,
  input logic        flag_frnd
);
  a_r1_nan_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $past(val_class) == 2'd3 |-> result[30:23] == 8'hFF && result[22]);

  a_r2_zero_sign_only: assert property (@(posedge clk) disable iff (!rst_n)
    $past(val_class) == 2'd0 |-> result[30:0] == 31'd0 &&
      !(flag_ovf || flag_unf || flag_inx || flag_frnd));

  a_r5_frnd_needs_inx: assert property (@(posedge clk) disable iff (!rst_n)
    flag_frnd |-> flag_inx);

  a_r9_unf_is_tiny: assert property (@(posedge clk) disable iff (!rst_n)
    flag_unf |-> result[30:23] == 8'h00 && !flag_ovf);

  a_r10_ovf_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    flag_ovf |-> (result[30:23] == 8'hFF && result[22:0] == 23'd0) ||
                 (result[30:23] == 8'hFE && result[22:0] == 23'h7FFFFF));

  a_r10_rz_never_inf: assert property (@(posedge clk) disable iff (!rst_n)
    flag_ovf && $past(rnd_mode) == 2'd1 |-> result[30:23] == 8'hFE);
endmodule

bind fp32_packer fp32_packer_chk chk_i (.*);

// File: tb/fp32_packer_tb_top.sv
module fp32_packer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  val_class = '0;
  logic        val_sign = 1'b0;
  logic [9:0]  val_exp = '0;
  logic [31:0] val_mant = '0;
  logic        val_sticky = 1'b0;
  logic [1:0]  rnd_mode = '0;
  logic        unf_trap_en = 1'b0;
  logic [31:0] result;
  logic        flag_ovf, flag_unf, flag_inx, flag_frnd;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  fp32_packer dut_i (
    .clk(clk), .rst_n(rst_n), .val_class(val_class), .val_sign(val_sign),
    .val_exp(val_exp), .val_mant(val_mant), .val_sticky(val_sticky),
    .rnd_mode(rnd_mode), .unf_trap_en(unf_trap_en), .result(result),
    .flag_ovf(flag_ovf), .flag_unf(flag_unf), .flag_inx(flag_inx), .flag_frnd(flag_frnd)
  );

  localparam int NV = 33;
  // {class, sign, exp, mant, sticky, mode, trap, expected word, {ovf,unf,inx,frnd}}
  localparam logic [84:0] VEC [NV] = '{
    {2'd1,1'b0,10'h000,32'h80000000,1'b0,2'd0,1'b0,32'h3F800000,4'b0000}, // R3
    {2'd1,1'b1,10'h001,32'hC0000000,1'b0,2'd0,1'b0,32'hC0400000,4'b0000}, // R3
    {2'd0,1'b1,10'h005,32'hFFFFFFFF,1'b1,2'd2,1'b1,32'h80000000,4'b0000}, // R2
    {2'd2,1'b0,10'h000,32'h00000000,1'b0,2'd0,1'b0,32'h7F800000,4'b0000}, // R2
    {2'd3,1'b0,10'h000,32'h81234500,1'b0,2'd0,1'b0,32'h7FC12345,4'b0000}, // R1
    {2'd3,1'b1,10'h000,32'hC0000000,1'b1,2'd1,1'b1,32'hFFC00000,4'b0000}, // R1
    {2'd1,1'b0,10'h000,32'h80000080,1'b0,2'd0,1'b0,32'h3F800000,4'b0010}, // R4 tie even
    {2'd1,1'b0,10'h000,32'h80000180,1'b0,2'd0,1'b0,32'h3F800002,4'b0011}, // R4 tie odd
    {2'd1,1'b0,10'h000,32'h800000C0,1'b0,2'd0,1'b0,32'h3F800001,4'b0011}, // R4
    {2'd1,1'b0,10'h000,32'h80000080,1'b1,2'd0,1'b0,32'h3F800001,4'b0011}, // R4 sticky input
    {2'd1,1'b0,10'h000,32'h800001FF,1'b0,2'd1,1'b0,32'h3F800001,4'b0010}, // R4 toward zero
    {2'd1,1'b0,10'h000,32'h80000001,1'b0,2'd2,1'b0,32'h3F800001,4'b0011}, // R4 R5
    {2'd1,1'b1,10'h000,32'h80000001,1'b0,2'd2,1'b0,32'hBF800000,4'b0010}, // R4 R5
    {2'd1,1'b1,10'h000,32'h80000001,1'b0,2'd3,1'b0,32'hBF800001,4'b0011}, // R4
    {2'd1,1'b0,10'h000,32'h80000001,1'b0,2'd3,1'b0,32'h3F800000,4'b0010}, // R4
    {2'd1,1'b0,10'h000,32'hFFFFFF80,1'b0,2'd0,1'b0,32'h40000000,4'b0011}, // R6
    {2'd1,1'b0,10'h080,32'h80000000,1'b0,2'd0,1'b0,32'h7F800000,4'b1000}, // R10
    {2'd1,1'b0,10'h080,32'h80000000,1'b0,2'd1,1'b0,32'h7F7FFFFF,4'b1000}, // R10
    {2'd1,1'b1,10'h080,32'h80000000,1'b0,2'd2,1'b0,32'hFF7FFFFF,4'b1000}, // R10
    {2'd1,1'b1,10'h080,32'h80000000,1'b0,2'd3,1'b0,32'hFF800000,4'b1000}, // R10
    {2'd1,1'b0,10'h080,32'h80000000,1'b0,2'd2,1'b0,32'h7F800000,4'b1000}, // R10
    {2'd1,1'b0,10'h07F,32'hFFFFFF80,1'b0,2'd0,1'b0,32'h7F800000,4'b1011}, // R10 R6
    {2'd1,1'b0,10'h07F,32'hFFFFFF00,1'b0,2'd0,1'b0,32'h7F7FFFFF,4'b0000}, // R3
    {2'd1,1'b0,10'h381,32'h80000000,1'b0,2'd0,1'b0,32'h00400000,4'b0000}, // R7
    {2'd1,1'b0,10'h381,32'h80000000,1'b0,2'd0,1'b1,32'h00400000,4'b0100}, // R9 trap
    {2'd1,1'b0,10'h36B,32'h80000000,1'b0,2'd0,1'b0,32'h00000001,4'b0000}, // R7
    {2'd1,1'b0,10'h36A,32'h80000000,1'b0,2'd0,1'b0,32'h00000000,4'b0110}, // R9
    {2'd1,1'b0,10'h36A,32'hC0000000,1'b0,2'd0,1'b0,32'h00000001,4'b0111}, // R7 R9
    {2'd1,1'b0,10'h381,32'hFFFFFFFF,1'b0,2'd0,1'b0,32'h00800000,4'b0011}, // R8
    {2'd1,1'b0,10'h381,32'hFFFFFFFF,1'b0,2'd0,1'b1,32'h00800000,4'b0011}, // R8
    {2'd1,1'b0,10'h270,32'h80000000,1'b0,2'd2,1'b0,32'h00000001,4'b0111}, // R7 clamp
    {2'd1,1'b0,10'h270,32'h80000000,1'b0,2'd0,1'b0,32'h00000000,4'b0110}, // R7 clamp
    {2'd1,1'b0,10'h382,32'h80000000,1'b0,2'd0,1'b0,32'h00800000,4'b0000}  // R7 boundary
  };

  task automatic check(input string tag, input logic [31:0] exp_w, input logic [3:0] exp_f);
    n_chk++;
    if (result !== exp_w || {flag_ovf, flag_unf, flag_inx, flag_frnd} !== exp_f) begin
      n_bad++;
      $display("FAIL %s: got %h/%b expected %h/%b", tag, result,
               {flag_ovf, flag_unf, flag_inx, flag_frnd}, exp_w, exp_f);
    end
  endtask

  task automatic drive(input logic [84:0] v);
    {val_class, val_sign, val_exp, val_mant, val_sticky, rnd_mode, unf_trap_en} = v[84:36];
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R11 reset state", 32'h0, 4'b0000);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i]);
      @(negedge clk);
      check($sformatf("vector %0d", i), VEC[i][35:4], VEC[i][3:0]);
    end
    @(negedge clk);
    drive(VEC[3]);
    check("R11 no change before edge", 32'h00800000, 4'b0000);
    @(negedge clk);
    check("R11 after edge", 32'h7F800000, 4'b0000);
    rst_n = 1'b0;
    @(negedge clk);
    check("R11 reset clears", 32'h0, 4'b0000);
    rst_n = 1'b1;
    drive(VEC[2]);
    @(negedge clk);
    check("R2 zero ignores other inputs", 32'h80000000, 4'b0000);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule